// File: doc/BRIEF.md
# Fragment Alpha and Depth Test Unit

This unit sits in a pixel pipeline and accepts one fragment per clock. Each fragment carries its source alpha, its incoming depth, the depth already held in the depth buffer, a per-fragment control word and a depth-mask bit. The unit applies a configurable alpha comparison against a reference value held in the control word. It also applies a configurable depth comparison of the incoming depth against the stored depth.

From the two results and a two-bit fail policy, the unit decides three write enables: colour channels, alpha channel and depth. A failed alpha test does not always discard the fragment. The fail policy can keep the colour write, keep the depth write, or keep the colour write without its alpha channel.

The unit also reports two flags for the scheduler above it. The first flag says whether any fragment could pass in a normal pass. When it is low, the fragment needs no processing at all. The second flag says whether a follow-up pass for failing fragments is needed. Results appear two clocks after the fragment enters, together with a valid bit.

Top module: `frag_test_unit`

## Requirements
- R1: Alpha method is control bits 3:1, reference is bits 11:4, alpha enable is bit 0. With the alpha test enabled, it compares source alpha against the reference: 0 never passes, 1 always passes, 2 passes when less, 3 when less or equal, 4 when equal, 5 when greater or equal, 6 when greater, 7 when not equal.
- R2: With bit 0 clear, the alpha test passes whatever the method and reference.
- R3: Depth enable is bit 16, depth method bits 18:17. With the depth test enabled, it compares incoming depth (unsigned) against stored depth: 0 never passes, 1 always passes, 2 passes when greater or equal, 3 when strictly greater.
- R4: With bit 16 clear, the depth test passes.
- R5: A fragment failing the depth test asserts none of the three write enables, whatever the alpha result and fail policy.
- R6: A fragment passing both tests writes colour, alpha and depth. A fragment passing depth but failing alpha uses the fail policy in bits 13:12. Policy 0 writes nothing. Policy 1 writes colour and alpha only. Policy 2 writes depth only. Policy 3 writes colour without alpha and no depth.
- R7: When the depth-mask input is high, the depth write enable stays low.
- R8: The first-pass flag is high unless the alpha test is enabled with method 0.
- R9: The second-pass flag is high when the alpha test is enabled, the method is not 1, and the fail policy is not 0.
- R10: Outputs follow the fragment's input cycle by exactly two clocks, with `out_valid` matching the input valid. While `out_valid` is low, every other output is low.
- R11: During synchronous active-low reset, all outputs go low and stay low until fragments arrive.
- R12: Control bits 14 and 15 (destination-alpha enable and mode) have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Fragment present this cycle |
| in_alpha | input | 8 | Source alpha |
| in_depth | input | 32 | Incoming fragment depth |
| in_stored_depth | input | 32 | Depth currently in the buffer |
| in_ctrl | input | 19 | Per-fragment test control word |
| in_depth_mask | input | 1 | High blocks the depth write |
| out_valid | output | 1 | Result present |
| out_color_we | output | 1 | Write colour channels |
| out_alpha_we | output | 1 | Write alpha channel |
| out_depth_we | output | 1 | Write depth |
| out_first_pass | output | 1 | Normal pass can produce output |
| out_second_pass | output | 1 | Follow-up pass for failing fragments needed |

## Verification
Two decisions can hit the same fragment in the same cycle: an alpha failure routed through a non-keep fail policy, and a depth failure. The depth failure must win. The bench provokes this by streaming fragments that fail both tests under each fail policy, back to back with fragments that fail only alpha. It judges each result against the reference model two clocks later. The depth mask is combined in the same way with the depth-only fail policy, and the depth write must stay low.

// File: rtl/ftu_pkg.sv
// Package: shared encodings and the layout of the fragment test control word.
// Assumes the control word is 19 bits with the field positions below.
package ftu_pkg;
    localparam int REF_W  = 8;
    localparam int CTRL_W = 19;

    typedef enum logic [2:0] {
        AM_NEVER = 3'd0, AM_ALWAYS = 3'd1, AM_LT = 3'd2, AM_LE = 3'd3,
        AM_EQ    = 3'd4, AM_GE     = 3'd5, AM_GT = 3'd6, AM_NE = 3'd7
    } alpha_meth_e;

    typedef enum logic [1:0] {
        DM_NEVER = 2'd0, DM_ALWAYS = 2'd1, DM_GE = 2'd2, DM_GT = 2'd3
    } depth_meth_e;

    typedef enum logic [1:0] {
        FP_KEEP = 2'd0, FP_COLOR = 2'd1, FP_DEPTH = 2'd2, FP_RGB = 2'd3
    } fail_pol_e;

    // Packed from bit 18 down to bit 0.
    typedef struct packed {
        depth_meth_e      z_meth;    // 18:17
        logic             z_en;      // 16
        logic             da_mode;   // 15
        logic             da_en;     // 14
        fail_pol_e        fail_pol;  // 13:12
        logic [REF_W-1:0] a_ref;     // 11:4
        alpha_meth_e      a_meth;    // 3:1
        logic             a_en;      // 0
    } test_ctrl_t;
endpackage

// File: rtl/ftu_alpha_cmp.sv
// Alpha comparator: combinational pass/fail of source alpha against a reference.
// Assumes unsigned operands; a disabled test always passes.
module ftu_alpha_cmp #(
    parameter int W = 8
) (
    input  logic                 en,
    input  ftu_pkg::alpha_meth_e meth,
    input  logic [W-1:0]         src,
    input  logic [W-1:0]         ref_val,
    output logic                 pass
);
    import ftu_pkg::*;

    // Select the comparison named by the method.
    always_comb begin
        unique case (meth)
            AM_NEVER:  pass = 1'b0;
            AM_ALWAYS: pass = 1'b1;
            AM_LT:     pass = (src <  ref_val);
            AM_LE:     pass = (src <= ref_val);
            AM_EQ:     pass = (src == ref_val);
            AM_GE:     pass = (src >= ref_val);
            AM_GT:     pass = (src >  ref_val);
            default:   pass = (src != ref_val);
        endcase
        if (!en) pass = 1'b1;
    end
endmodule

// File: rtl/ftu_depth_cmp.sv
// Depth comparator: combinational pass/fail of incoming depth against stored depth.
// Assumes unsigned depth values; a disabled test always passes.
module ftu_depth_cmp #(
    parameter int W = 32
) (
    input  logic                 en,
    input  ftu_pkg::depth_meth_e meth,
    input  logic [W-1:0]         z_new,
    input  logic [W-1:0]         z_old,
    output logic                 pass
);
    import ftu_pkg::*;

    // Select the comparison named by the method.
    always_comb begin
        unique case (meth)
            DM_NEVER:  pass = 1'b0;
            DM_ALWAYS: pass = 1'b1;
            DM_GE:     pass = (z_new >= z_old);
            default:   pass = (z_new >  z_old);
        endcase
        if (!en) pass = 1'b1;
    end
endmodule

// File: rtl/ftu_write_sel.sv
// Write selector: turns the two test results, the fail policy and the depth
// mask into the colour, alpha and depth write enables.
// Assumes the depth result dominates the alpha result.
module ftu_write_sel (
    input  logic               alpha_pass,
    input  logic               depth_pass,
    input  ftu_pkg::fail_pol_e fail_pol,
    input  logic               depth_mask,
    output logic               color_we,
    output logic               alpha_we,
    output logic               depth_we
);
    import ftu_pkg::*;

    logic z_raw;

    // Choose enables from the alpha result and the fail policy, then gate.
    always_comb begin
        color_we = 1'b0;
        alpha_we = 1'b0;
        z_raw    = 1'b0;
        if (alpha_pass) begin
            color_we = 1'b1;
            alpha_we = 1'b1;
            z_raw    = 1'b1;
        end else begin
            unique case (fail_pol)
                FP_KEEP:  ;
                FP_COLOR: begin color_we = 1'b1; alpha_we = 1'b1; end
                FP_DEPTH: z_raw = 1'b1;
                default:  color_we = 1'b1;
            endcase
        end
        if (!depth_pass) begin
            color_we = 1'b0;
            alpha_we = 1'b0;
            z_raw    = 1'b0;
        end
        depth_we = z_raw & ~depth_mask;
    end
endmodule

// File: rtl/frag_test_unit.sv
// Fragment alpha/depth test unit, two-stage pipeline.
// Stage 1 registers the test results and the pass flags; stage 2 registers
// the write enables. Assumes one fragment per cycle and no back-pressure.
module frag_test_unit #(
    parameter int ALPHA_W = ftu_pkg::REF_W,
    parameter int DEPTH_W = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic [ALPHA_W-1:0]         in_alpha,
    input  logic [DEPTH_W-1:0]         in_depth,
    input  logic [DEPTH_W-1:0]         in_stored_depth,
    input  logic [ftu_pkg::CTRL_W-1:0] in_ctrl,
    input  logic                       in_depth_mask,
    output logic                       out_valid,
    output logic                       out_color_we,
    output logic                       out_alpha_we,
    output logic                       out_depth_we,
    output logic                       out_first_pass,
    output logic                       out_second_pass
);
    import ftu_pkg::*;

    test_ctrl_t ctl;
    logic       a_pass, z_pass, first_nd, second_nd;
    logic       unused_dst;

    logic       s1_valid, s1_apass, s1_zpass, s1_mask, s1_first, s1_second;
    fail_pol_e  s1_fail;
    logic       sel_color, sel_alpha, sel_depth;

    assign ctl        = test_ctrl_t'(in_ctrl);
    assign unused_dst = ^{ctl.da_en, ctl.da_mode};

    ftu_alpha_cmp #(.W(ALPHA_W)) u_acmp (
        .en(ctl.a_en), .meth(ctl.a_meth), .src(in_alpha),
        .ref_val(ctl.a_ref), .pass(a_pass)
    );

    ftu_depth_cmp #(.W(DEPTH_W)) u_zcmp (
        .en(ctl.z_en), .meth(ctl.z_meth), .z_new(in_depth),
        .z_old(in_stored_depth), .pass(z_pass)
    );

    // Pass flags depend only on the alpha settings.
    always_comb begin
        first_nd  = !(ctl.a_en && ctl.a_meth == AM_NEVER);
        second_nd = ctl.a_en && ctl.a_meth != AM_ALWAYS && ctl.fail_pol != FP_KEEP;
    end

    // Stage 1: capture comparison results and policy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid  <= 1'b0;
            s1_apass  <= 1'b0;
            s1_zpass  <= 1'b0;
            s1_mask   <= 1'b0;
            s1_first  <= 1'b0;
            s1_second <= 1'b0;
            s1_fail   <= FP_KEEP;
        end else begin
            s1_valid  <= in_valid;
            s1_apass  <= a_pass;
            s1_zpass  <= z_pass;
            s1_mask   <= in_depth_mask;
            s1_first  <= first_nd;
            s1_second <= second_nd;
            s1_fail   <= ctl.fail_pol;
        end
    end

    ftu_write_sel u_sel (
        .alpha_pass(s1_apass), .depth_pass(s1_zpass), .fail_pol(s1_fail),
        .depth_mask(s1_mask), .color_we(sel_color), .alpha_we(sel_alpha),
        .depth_we(sel_depth)
    );

    // Stage 2: register the enables, quieted when no fragment is present.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid       <= 1'b0;
            out_color_we    <= 1'b0;
            out_alpha_we    <= 1'b0;
            out_depth_we    <= 1'b0;
            out_first_pass  <= 1'b0;
            out_second_pass <= 1'b0;
        end else begin
            out_valid       <= s1_valid;
            out_color_we    <= s1_valid & sel_color;
            out_alpha_we    <= s1_valid & sel_alpha;
            out_depth_we    <= s1_valid & sel_depth;
            out_first_pass  <= s1_valid & s1_first;
            out_second_pass <= s1_valid & s1_second;
        end
    end
endmodule

// File: rtl/ftu_checker.sv
// Checker for frag_test_unit: port-level timing properties.
// Counts cycles since reset so two-cycle lookbacks never reach into reset.
module ftu_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [18:0] in_ctrl,
    input logic        in_depth_mask,
    input logic        out_valid,
    input logic        out_color_we,
    input logic        out_alpha_we,
    input logic        out_depth_we,
    input logic        out_first_pass,
    input logic        out_second_pass
);
    logic [1:0] since_rst;
    logic       hist_ok;

    // Saturating count of clean cycles after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) since_rst <= 2'd0;
        else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
    end
    assign hist_ok = (since_rst == 2'd2);

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        hist_ok |-> (out_valid == $past(in_valid, 2))); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !(out_color_we | out_alpha_we | out_depth_we | out_first_pass | out_second_pass)); // R10
    AST_DEPTH_NEVER_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (hist_ok && $past(in_ctrl[16], 2) && $past(in_ctrl[18:17], 2) == 2'd0)
        |-> !(out_color_we | out_alpha_we | out_depth_we)); // R5
    AST_MASK_BLOCKS_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
        (hist_ok && $past(in_depth_mask, 2)) |-> !out_depth_we); // R7
    AST_ALPHA_WITH_COLOR: assert property (@(posedge clk) disable iff (!rst_n)
        out_alpha_we |-> out_color_we); // R6
    AST_NEVER_SKIPS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (hist_ok && $past(in_ctrl[0], 2) && $past(in_ctrl[3:1], 2) == 3'd0)
        |-> !out_first_pass); // R8
endmodule

bind frag_test_unit ftu_checker u_ftu_checker (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ctrl(in_ctrl),
    .in_depth_mask(in_depth_mask), .out_valid(out_valid),
    .out_color_we(out_color_we), .out_alpha_we(out_alpha_we),
    .out_depth_we(out_depth_we), .out_first_pass(out_first_pass),
    .out_second_pass(out_second_pass)
);

// File: tb/frag_test_unit_bench.sv
// Directed bench for frag_test_unit with a reference model and a
// two-deep expectation pipeline; one step per clock, checked at negedge.
module frag_test_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_alpha = '0;
    logic [31:0] in_depth = '0;
    logic [31:0] in_stored_depth = '0;
    logic [18:0] in_ctrl = '0;
    logic        in_depth_mask = 1'b0;
    logic        out_valid, out_color_we, out_alpha_we, out_depth_we;
    logic        out_first_pass, out_second_pass;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    logic [5:0] exp_q0, exp_q1;
    string      tag_q0, tag_q1;

    always #2.5 clk = ~clk;

    frag_test_unit u_frag_test_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_alpha(in_alpha),
        .in_depth(in_depth), .in_stored_depth(in_stored_depth),
        .in_ctrl(in_ctrl), .in_depth_mask(in_depth_mask),
        .out_valid(out_valid), .out_color_we(out_color_we),
        .out_alpha_we(out_alpha_we), .out_depth_we(out_depth_we),
        .out_first_pass(out_first_pass), .out_second_pass(out_second_pass)
    );

    function automatic logic [18:0] mk(bit aen, int am, int aref, int fp,
                                       bit zen, int zm, int dst);
        logic [18:0] c = '0;
        c[0]     = aen;
        c[3:1]   = am[2:0];
        c[11:4]  = aref[7:0];
        c[13:12] = fp[1:0];
        c[15:14] = dst[1:0];
        c[16]    = zen;
        c[18:17] = zm[1:0];
        return c;
    endfunction

    // Reference: {valid, colour, alpha, depth, first, second}.
    function automatic logic [5:0] model(bit v, logic [18:0] c, logic [7:0] a,
                                         logic [31:0] z, logic [31:0] zs, bit m);
        bit ap, zp, cw, aw, dw, f1, f2;
        if (!v) return 6'b0;
        case (c[3:1])
            3'd0: ap = 0;
            3'd1: ap = 1;
            3'd2: ap = a < c[11:4];
            3'd3: ap = a <= c[11:4];
            3'd4: ap = a == c[11:4];
            3'd5: ap = a >= c[11:4];
            3'd6: ap = a > c[11:4];
            default: ap = a != c[11:4];
        endcase
        if (!c[0]) ap = 1;
        case (c[18:17])
            2'd0: zp = 0;
            2'd1: zp = 1;
            2'd2: zp = z >= zs;
            default: zp = z > zs;
        endcase
        if (!c[16]) zp = 1;
        if (ap) begin cw = 1; aw = 1; dw = 1; end
        else case (c[13:12])
            2'd0: begin cw = 0; aw = 0; dw = 0; end
            2'd1: begin cw = 1; aw = 1; dw = 0; end
            2'd2: begin cw = 0; aw = 0; dw = 1; end
            default: begin cw = 1; aw = 0; dw = 0; end
        endcase
        if (!zp) begin cw = 0; aw = 0; dw = 0; end
        if (m) dw = 0;
        f1 = !(c[0] && c[3:1] == 3'd0);
        f2 = c[0] && c[3:1] != 3'd1 && c[13:12] != 2'd0;
        return {1'b1, cw, aw, dw, f1, f2};
    endfunction

    // One clock: check the result of two steps ago, then drive a new fragment.
    task automatic step(bit v, logic [18:0] c, logic [7:0] a, logic [31:0] z,
                        logic [31:0] zs, bit m, string tag);
        logic [5:0] got;
        @(negedge clk);
        got = {out_valid, out_color_we, out_alpha_we, out_depth_we,
               out_first_pass, out_second_pass};
        n_checks++;
        if (got !== exp_q1) begin
            n_errors++;
            $display("FAIL %s: got %b expected %b", tag_q1, got, exp_q1);
        end
        exp_q1 = exp_q0;
        tag_q1 = tag_q0;
        exp_q0 = model(v, c, a, z, zs, m);
        tag_q0 = tag;
        in_valid = v; in_ctrl = c; in_alpha = a;
        in_depth = z; in_stored_depth = zs; in_depth_mask = m;
    endtask

    task automatic flush(string tag);
        step(0, '0, 0, 0, 0, 0, tag);
        step(0, '0, 0, 0, 0, 0, tag);
    endtask

    task automatic t_reset;
        exp_q0 = '0; exp_q1 = '0; tag_q0 = "R11"; tag_q1 = "R11";
        in_valid = 1'b1; in_ctrl = mk(0, 1, 0, 0, 0, 1, 0);
        repeat (4) @(posedge clk);
        @(negedge clk);
        n_checks++;
        if ({out_valid, out_color_we, out_depth_we, out_first_pass} !== 4'b0) begin
            n_errors++;
            $display("FAIL R11: outputs not low in reset, got %b expected 0000",
                     {out_valid, out_color_we, out_depth_we, out_first_pass});
        end
        in_valid = 1'b0;
        rst_n = 1'b1;
        flush("R11");
    endtask

    task automatic t_alpha_methods; // R1
        for (int m = 0; m < 8; m++)
            for (int d = -1; d <= 1; d++)
                step(1, mk(1, m, 8'h80, 0, 0, 0, 0), 8'(128 + d), 0, 0, 0, "R1");
        flush("R1");
    endtask

    task automatic t_alpha_off; // R2
        step(1, mk(0, 0, 8'h80, 0, 0, 0, 0), 8'h10, 0, 0, 0, "R2");
        step(1, mk(0, 4, 8'h33, 0, 0, 0, 0), 8'h34, 0, 0, 0, "R2");
        flush("R2");
    endtask

    task automatic t_depth_methods; // R3
        for (int m = 0; m < 4; m++)
            for (int d = -1; d <= 1; d++)
                step(1, mk(0, 1, 0, 0, 1, m, 0), 8'h00, 32'(1000 + d), 32'd1000, 0, "R3");
        step(1, mk(0, 1, 0, 0, 1, 3, 0), 0, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 0, "R3");
        flush("R3");
    endtask

    task automatic t_depth_off; // R4
        step(1, mk(0, 1, 0, 0, 0, 0, 0), 0, 5, 9, 0, "R4");
        flush("R4");
    endtask

    task automatic t_depth_wins; // R5: depth fail against every policy
        for (int fp = 0; fp < 4; fp++) begin
            step(1, mk(1, 0, 0, fp, 1, 0, 0), 0, 5, 1, 0, "R5");
            step(1, mk(1, 0, 0, fp, 1, 1, 0), 0, 5, 1, 0, "R5");
        end
        step(1, mk(1, 1, 0, 1, 1, 3, 0), 0, 7, 7, 0, "R5");
        flush("R5");
    endtask

    task automatic t_fail_policies; // R6
        for (int fp = 0; fp < 4; fp++)
            step(1, mk(1, 2, 8'h40, fp, 1, 2, 0), 8'h90, 10, 10, 0, "R6");
        step(1, mk(1, 2, 8'h40, 3, 1, 2, 0), 8'h20, 10, 10, 0, "R6");
        flush("R6");
    endtask

    task automatic t_mask; // R7
        step(1, mk(1, 0, 0, 2, 0, 0, 0), 0, 0, 0, 1, "R7");
        step(1, mk(0, 1, 0, 0, 0, 0, 0), 0, 0, 0, 1, "R7");
        step(1, mk(1, 0, 0, 2, 0, 0, 0), 0, 0, 0, 0, "R7");
        flush("R7");
    endtask

    task automatic t_pass_flags; // R8 and R9
        step(1, mk(1, 0, 0, 0, 0, 1, 0), 0, 0, 0, 0, "R8");
        step(1, mk(0, 0, 0, 2, 0, 1, 0), 0, 0, 0, 0, "R8");
        step(1, mk(1, 1, 0, 3, 0, 1, 0), 0, 0, 0, 0, "R9");
        step(1, mk(1, 5, 0, 0, 0, 1, 0), 0, 0, 0, 0, "R9");
        step(1, mk(1, 5, 0, 1, 0, 1, 0), 0, 0, 0, 0, "R9");
        flush("R9");
    endtask

    task automatic t_gaps; // R10: invalid slots carrying writable data
        step(1, mk(0, 1, 0, 0, 0, 1, 0), 0, 0, 0, 0, "R10");
        step(0, mk(0, 1, 0, 0, 0, 1, 0), 0, 0, 0, 0, "R10");
        step(1, mk(1, 0, 0, 0, 0, 1, 0), 0, 0, 0, 0, "R10");
        step(0, mk(1, 0, 0, 3, 0, 1, 0), 0, 0, 0, 0, "R10");
        flush("R10");
    endtask

    task automatic t_dst_bits; // R12
        for (int db = 0; db < 4; db++) begin
            step(1, mk(1, 2, 8'h40, 1, 1, 2, db), 8'h50, 3, 4, 0, "R12");
            step(1, mk(1, 4, 8'h40, 3, 1, 3, db), 8'h40, 9, 4, 0, "R12");
        end
        flush("R12");
    endtask

    initial begin
        t_reset;
        t_alpha_methods;
        t_alpha_off;
        t_depth_methods;
        t_depth_off;
        t_depth_wins;
        t_fail_policies;
        t_mask;
        t_pass_flags;
        t_gaps;
        t_dst_bits;
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL R10: watchdog expired, got hang expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule